// File: doc/BRIEF.md
# Frame Lock Hysteresis Tracker

This block decides whether a receiver is locked onto an incoming frame stream. An upstream stage marks the end of each received frame with a one-cycle strobe and reports whether that frame held any error. The tracker turns that sequence of per-frame verdicts into a lock decision.

Lock is tracked by four states and a confidence counter shared by all of them. The counter climbs on error-free frames and falls on errored ones, and it saturates at zero and at a threshold set at run time. Lock is granted only after a run of good frames as long as the threshold. Once lock is held, it is released only after enough errors to bring the counter down to zero. A single bad frame therefore does not drop lock, and a single good frame does not grant it.

The current state, a locked flag and the counter value are all visible at the ports. This lets a monitor see both the decision and how close it is to changing.

Top module: `flk_lock_tracker`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state is Unlocked (code 0) and the counter is 0.
- R2: The state output uses the codes Unlocked=0, Locking=1, Locked=2 and Unlocking=3. The locked output is high exactly when the state is Locked or Unlocking.
- R3: On a clock edge where frame_valid is low, the state and the counter keep their values, whatever frame_err and threshold hold.
- R4: In Unlocked, an errored frame leaves the state Unlocked with the counter at 0. An error-free frame sets the counter to 1 and moves to Locking, or straight to Locked when the effective threshold is 1.
- R5: In Locking, an error-free frame increments the counter. When the new value reaches the effective threshold, the counter is set to the threshold and the state becomes Locked.
- R6: In Locking, an errored frame clears the counter to 0 and returns the state to Unlocked.
- R7: In Locked, an error-free frame keeps the state Locked and sets the counter to the effective threshold. An errored frame sets the counter to threshold-1 and moves to Unlocking, or to Unlocked when that value is 0.
- R8: In Unlocking, an error-free frame increments the counter, and reaching the effective threshold moves to Locked. An errored frame decrements the counter, and reaching 0 moves to Unlocked.
- R9: A threshold input of 0 behaves as a threshold of 1.
- R10: The state, counter and locked outputs reflect a frame one clock after the edge at which its strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe, one per received frame |
| frame_err | input | 1 | Frame contained errors; used only with frame_valid |
| threshold | input | CNT_W | Number of good frames needed for lock; 0 behaves as 1 |
| state | output | 2 | Current lock state code |
| locked | output | 1 | High in Locked and Unlocking |
| count | output | CNT_W | Confidence counter value |

## Verification
Every frame decision takes effect at the rising edge that samples its strobe, so the state and counter are due one edge later. The locked flag follows the state with no further delay. The bench drives each stimulus just after a falling edge and updates its behavioural model with that stimulus at once. At the next falling edge, after exactly one rising edge has passed, it compares all three outputs with the model. The stimulus runs idle gaps, error bursts, a mid-run reset and thresholds of 0, 1, small and full-scale values, so that each transition is met with the counter at its limits.

// File: rtl/flk_pkg.sv
// Shared types of the frame lock tracker: the state codes seen at the
// port and the operations the state controller requests of the counter.
package flk_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCKED  = 2'd0,
        ST_LOCKING   = 2'd1,
        ST_LOCKED    = 2'd2,
        ST_UNLOCKING = 2'd3
    } flk_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_ONE,
        OP_INC,
        OP_DEC,
        OP_LOAD_THR,
        OP_LOAD_THR_M1
    } flk_op_e;
endpackage

// File: rtl/flk_thr_clamp.sv
// Threshold conditioner: maps a run-time threshold of zero to one so that
// the rest of the tracker may assume thr_eff >= 1. Purely combinational.
module flk_thr_clamp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] thr_in,
    output logic [CNT_W-1:0] thr_eff,
    output logic             thr_is_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Replace a zero threshold with the smallest meaningful one.
    always_comb begin
        thr_eff    = (thr_in == '0) ? ONE : thr_in;
        thr_is_one = (thr_eff == ONE);
    end
endmodule

// File: rtl/flk_conf_counter.sv
// Confidence counter: applies one operation per cycle as ordered by the
// state controller, saturating at zero and at the effective threshold.
// Assumes thr_eff >= 1. Also reports whether an increment would reach the
// threshold and whether a decrement would reach zero.
module flk_conf_counter
    import flk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  flk_op_e          op,
    input  logic [CNT_W-1:0] thr_eff,
    output logic [CNT_W-1:0] count,
    output logic             inc_hits_thr,
    output logic             dec_hits_zero
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] count_plus;
    logic [CNT_W-1:0] count_next;

    // Look-ahead flags used by the state controller.
    always_comb begin
        count_plus    = {1'b0, count} + EXT_W'(1);
        inc_hits_thr  = (count_plus >= {1'b0, thr_eff});
        dec_hits_zero = (count <= CNT_W'(1));
    end

    // Next counter value for the requested operation.
    always_comb begin
        unique case (op)
            OP_CLEAR:       count_next = '0;
            OP_ONE:         count_next = CNT_W'(1);
            OP_INC:         count_next = inc_hits_thr ? thr_eff : count_plus[CNT_W-1:0];
            OP_DEC:         count_next = dec_hits_zero ? '0 : count - CNT_W'(1);
            OP_LOAD_THR:    count_next = thr_eff;
            OP_LOAD_THR_M1: count_next = thr_eff - CNT_W'(1);
            default:        count_next = count;
        endcase
    end

    // Counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_next;
    end
endmodule

// File: rtl/flk_state_ctrl.sv
// Lock state controller: four-state machine that advances only on frame
// strobes and tells the counter what to do for each frame. Relies on the
// counter's look-ahead flags and on thr_is_one from the threshold clamp.
module flk_state_ctrl
    import flk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_valid,
    input  logic       frame_err,
    input  logic       inc_hits_thr,
    input  logic       dec_hits_zero,
    input  logic       thr_is_one,
    output flk_state_e state,
    output flk_op_e    op
);
    flk_state_e state_next;

    // Per-frame transition and counter operation selection.
    always_comb begin
        state_next = state;
        op         = OP_HOLD;
        if (frame_valid) begin
            unique case (state)
                ST_UNLOCKED: begin
                    if (frame_err) begin
                        op = OP_CLEAR;
                    end else begin
                        op         = OP_ONE;
                        state_next = thr_is_one ? ST_LOCKED : ST_LOCKING;
                    end
                end
                ST_LOCKING: begin
                    if (frame_err) begin
                        op         = OP_CLEAR;
                        state_next = ST_UNLOCKED;
                    end else begin
                        op = OP_INC;
                        if (inc_hits_thr) state_next = ST_LOCKED;
                    end
                end
                ST_LOCKED: begin
                    if (frame_err) begin
                        op         = OP_LOAD_THR_M1;
                        state_next = thr_is_one ? ST_UNLOCKED : ST_UNLOCKING;
                    end else begin
                        op = OP_LOAD_THR;
                    end
                end
                default: begin
                    if (frame_err) begin
                        op = OP_DEC;
                        if (dec_hits_zero) state_next = ST_UNLOCKED;
                    end else begin
                        op = OP_INC;
                        if (inc_hits_thr) state_next = ST_LOCKED;
                    end
                end
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_UNLOCKED;
        else        state <= state_next;
    end
endmodule

// File: rtl/flk_lock_tracker.sv
// Frame lock tracker top: joins the threshold clamp, the state controller
// and the confidence counter. Assumes one frame_valid strobe per frame and
// that frame_err is meaningful only while frame_valid is high.
module flk_lock_tracker
    import flk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_err,
    input  logic [CNT_W-1:0] threshold,
    output logic [1:0]       state,
    output logic             locked,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] thr_eff;
    logic             thr_is_one;
    logic             inc_hits_thr;
    logic             dec_hits_zero;
    flk_state_e       cur_state;
    flk_op_e          cnt_op;

    flk_thr_clamp #(.CNT_W(CNT_W)) u_clamp (
        .thr_in     (threshold),
        .thr_eff    (thr_eff),
        .thr_is_one (thr_is_one)
    );

    flk_state_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid   (frame_valid),
        .frame_err     (frame_err),
        .inc_hits_thr  (inc_hits_thr),
        .dec_hits_zero (dec_hits_zero),
        .thr_is_one    (thr_is_one),
        .state         (cur_state),
        .op            (cnt_op)
    );

    flk_conf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .op            (cnt_op),
        .thr_eff       (thr_eff),
        .count         (count),
        .inc_hits_thr  (inc_hits_thr),
        .dec_hits_zero (dec_hits_zero)
    );

    // Port view of the state and the lock flag.
    always_comb begin
        state  = cur_state;
        locked = (cur_state == ST_LOCKED) || (cur_state == ST_UNLOCKING);
    end
endmodule

// File: rtl/flk_lock_tracker_chk.sv
// Checker for the frame lock tracker, bound to every instance of the top.
// Watches only ports; all properties are clocked and disabled in reset.
module flk_lock_tracker_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_valid,
    input logic             frame_err,
    input logic [CNT_W-1:0] threshold,
    input logic [1:0]       state,
    input logic             locked,
    input logic [CNT_W-1:0] count
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> ($stable(state) && $stable(count))); // R3

    AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0) |-> (count == '0)); // R4

    AST_FIRST_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_err && state == 2'd0) |=> (count == CNT_W'(1) && state != 2'd0)); // R4

    AST_LOCKING_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_err && state == 2'd1) |=> (state == 2'd0 && count == '0)); // R6

    AST_LOCKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_err && state == 2'd2) |=> (state == 2'd2)); // R7

    AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_err && state == 2'd2) |=> (state != 2'd2 && state != 2'd1)); // R7

    AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1) |-> !locked); // R2

    AST_UNLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_err && state == 2'd3) |=> (state == 2'd3 || state == 2'd0)); // R8
endmodule

bind flk_lock_tracker flk_lock_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .threshold   (threshold),
    .state       (state),
    .locked      (locked),
    .count       (count)
);

// File: tb/flk_lock_tracker_tb.sv
// Bench for the frame lock tracker: a behavioural integer model advanced
// with every driven stimulus and compared with the outputs every cycle.
module flk_lock_tracker_tb;
    localparam int CNT_W  = 8;
    localparam int CLK_NS = 10;
    localparam int MAX_CYCLES = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_valid = 1'b0;
    logic             frame_err = 1'b0;
    logic [CNT_W-1:0] threshold = CNT_W'(4);
    logic [1:0]       state;
    logic             locked;
    logic [CNT_W-1:0] count;

    int n_checks = 0;
    int n_fail = 0;
    int m_state = 0;
    int m_cnt = 0;
    string m_tag = "R1";
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    flk_lock_tracker #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_err(frame_err),
        .threshold(threshold), .state(state), .locked(locked), .count(count)
    );

    // Model of one clock edge from the requirements (R1 to R9).
    task automatic model_step(input bit rn, input bit v, input bit e, input int thr);
        int t;
        t = (thr == 0) ? 1 : thr; // R9
        if (!rn) begin m_state = 0; m_cnt = 0; m_tag = "R1"; return; end
        if (!v) begin m_tag = "R3"; return; end
        case (m_state)
            0: begin m_tag = "R4";
                if (e) m_cnt = 0;
                else begin m_cnt = 1; m_state = (t == 1) ? 2 : 1; end
            end
            1: begin
                if (e) begin m_tag = "R6"; m_cnt = 0; m_state = 0; end
                else begin m_tag = "R5";
                    if (m_cnt + 1 >= t) begin m_cnt = t; m_state = 2; end
                    else m_cnt = m_cnt + 1;
                end
            end
            2: begin m_tag = "R7";
                if (!e) m_cnt = t;
                else begin m_cnt = t - 1; m_state = (m_cnt == 0) ? 0 : 3; end
            end
            default: begin m_tag = "R8";
                if (!e) begin
                    if (m_cnt + 1 >= t) begin m_cnt = t; m_state = 2; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt <= 1) begin m_cnt = 0; m_state = 0; end
                    else m_cnt = m_cnt - 1;
                end
            end
        endcase
        if (thr == 0) m_tag = "R9";
    endtask

    // Compare outputs one edge after the stimulus (R10) and the flag (R2).
    task automatic compare();
        bit exp_lock;
        exp_lock = (m_state == 2) || (m_state == 3);
        n_checks++;
        if (int'(state) != m_state || int'(count) != m_cnt) begin
            n_fail++;
            $display("FAIL %s/R10 state=%0d count=%0d expected state=%0d count=%0d",
                     m_tag, state, count, m_state, m_cnt);
        end
        n_checks++;
        if (locked !== exp_lock) begin
            n_fail++;
            $display("FAIL R2 locked=%0b expected %0b (state %0d)", locked, exp_lock, m_state);
        end
    endtask

    // One cycle: drive after a falling edge, check at the next one.
    task automatic cycle(input bit rn, input bit v, input bit e, input int thr);
        rst_n = rn; frame_valid = v; frame_err = e; threshold = CNT_W'(thr);
        model_step(rn, v, e, thr);
        @(negedge clk);
        compare();
    endtask

    // Burst of frames with a given error chance (percent) and idle gaps.
    task automatic run(input int n, input int thr, input int err_pct, input int idle_pct);
        for (int i = 0; i < n; i++) begin
            bit v, e;
            v = ($urandom_range(99) >= idle_pct);
            e = ($urandom_range(99) < err_pct);
            cycle(1'b1, v, e, thr);
        end
    endtask

    initial begin
        @(negedge clk);
        cycle(1'b0, 1'b1, 1'b0, 4);            // R1 reset state
        cycle(1'b0, 1'b0, 1'b0, 4);
        // Directed lock with threshold 4: R4, R5
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0, 4);
        cycle(1'b1, 1'b0, 1'b1, 4);            // R3 ignored error without strobe
        cycle(1'b1, 1'b1, 1'b1, 4);            // R7 into Unlocking
        cycle(1'b1, 1'b1, 1'b0, 4);            // R8 back to Locked
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 4); // R8 to Unlocked
        cycle(1'b1, 1'b1, 1'b1, 4);            // R4 error in Unlocked
        cycle(1'b1, 1'b1, 1'b0, 4);
        cycle(1'b1, 1'b1, 1'b1, 4);            // R6 error in Locking
        // Threshold 1 and 0: R4, R7, R9
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0, 1);
        cycle(1'b1, 1'b1, 1'b1, 1);
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0, 0);
        cycle(1'b1, 1'b1, 1'b1, 0);
        // Mixed patterns
        run(400, 4, 10, 20);
        run(400, 7, 30, 10);
        run(300, 1, 40, 30);
        run(300, 0, 25, 30);
        cycle(1'b0, 1'b1, 1'b0, 7);            // R1 mid-run reset
        run(600, 255, 2, 5);
        for (int i = 0; i < 260; i++) cycle(1'b1, 1'b1, 1'b1, 255);
        run(800, 12, 15, 20);
        run(400, 3, 50, 10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired R10 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule